// File: doc/BRIEF.md
# Array Sum Engine

This block adds up a fixed run of consecutive words held in an external synchronous memory. A one-cycle `start` pulse launches a pass. A state machine then walks an index from zero upward. For each word it issues a read strobe with the index as the address and captures the returned word one cycle later. It adds that word into a wide accumulator and then steps the index. When the index reaches the word count, the block raises `done` and holds the final sum.

The datapath has three registers: the accumulator, the index and the captured read data. Each register loads through a 2-to-1 multiplexer that picks either the clear value or the freshly computed value. The multiplexer is qualified by a written-out clock enable.

A build-time parameter selects the adder arrangement:
- With `SHARED_ADDER = 0`, there are two adders: one for the index and one for the sum.
- With `SHARED_ADDER = 1`, a single adder with multiplexed operands serves both. The increment and the accumulation fall in different states, so the adder never has to do both in the same cycle.

Top module: `arrsum_engine`

## Requirements
- R1: While reset is applied, and after it is released with no start, `done` is 0, `sum` is 0 and `mem_rd` is 0.
- R2: A start pulse seen while idle or done clears the accumulator and the index. `sum` reads 0 on the cycle after the clearing state.
- R3: Each read asserts `mem_rd` for exactly one cycle. Across one pass the addresses are 0, 1, ..., WORDS-1, each issued once and in ascending order.
- R4: Read data is taken only in the cycle after the strobe. Values on `mem_rdata` in any other cycle have no effect on the sum.
- R5: The final `sum` equals the arithmetic sum of the WORDS words. `sum` is DATA_W + clog2(WORDS) bits wide, so WORDS full-scale words do not wrap.
- R6: Once `done` is high, `done` and `sum` stay unchanged until the next start pulse.
- R7: A start pulse received while a pass is in progress is ignored. The pass ends with the same sum and the same number of reads.
- R8: The shared-adder build produces the same addresses, strobes, sum and timing as the two-adder build. The increment and the accumulation are never requested in the same cycle.
- R9: Each word costs five cycles. `done` rises 5*WORDS+2 clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that launches a pass when idle or done |
| mem_addr | output | clog2(WORDS) | Word address for the external memory |
| mem_rd | output | 1 | Read strobe; data is expected on the next cycle |
| mem_rdata | input | DATA_W | Read data returned one cycle after the strobe |
| sum | output | DATA_W+clog2(WORDS) | Accumulated sum |
| done | output | 1 | High when the pass has finished, until the next start |

## Verification
Two cases are hard to reach from the ports: a start pulse that arrives mid-pass, and read data that is wrong in every cycle except the one capture cycle.

The bench's memory model drives a changing junk value on `mem_rdata` in every cycle except the one after a strobe. Any capture in the wrong cycle therefore corrupts the sum.

One pass pulses `start` again roughly a hundred cycles in, then checks that the sum, the read count and the cycle count are unchanged. Both adder builds run side by side on the same stimulus, so any divergence in strobe or address timing is caught cycle by cycle.

// File: rtl/arrsum_pkg.sv
package arrsum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_CHECK = 3'd2,
    ST_FETCH = 3'd3,
    ST_GRAB  = 3'd4,
    ST_ADD   = 3'd5,
    ST_STEP  = 3'd6,
    ST_FIN   = 3'd7
  } seq_state_t;

endpackage

// File: rtl/arrsum_ctrl.sv
module arrsum_ctrl
  import arrsum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic idx_below,
  output logic clr_en,
  output logic rd_en,
  output logic cap_en,
  output logic add_en,
  output logic inc_en,
  output logic fin
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_CHECK;
      ST_CHECK: state_d = idx_below ? ST_FETCH : ST_FIN;
      ST_FETCH: state_d = ST_GRAB;
      ST_GRAB:  state_d = ST_ADD;
      ST_ADD:   state_d = ST_STEP;
      ST_STEP:  state_d = ST_CHECK;
      ST_FIN:   if (start) state_d = ST_CLEAR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign clr_en = (state_q == ST_CLEAR);
  assign rd_en  = (state_q == ST_FETCH);
  assign cap_en = (state_q == ST_GRAB);
  assign add_en = (state_q == ST_ADD);
  assign inc_en = (state_q == ST_STEP);
  assign fin    = (state_q == ST_FIN);

  // R4
  capture_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> cap_en && !rd_en);

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fin && state_q != ST_IDLE) |=> !clr_en);

endmodule

// File: rtl/arrsum_dpath.sv
module arrsum_dpath #(
  parameter int DATA_W       = 8,
  parameter int WORDS        = 128,
  parameter bit SHARED_ADDER = 1'b0,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int IDX_W  = ADDR_W + 1,
  localparam int ACC_W  = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              cap_en,
  input  logic              add_en,
  input  logic              inc_en,
  input  logic [DATA_W-1:0] rdata,
  output logic              idx_below,
  output logic [ADDR_W-1:0] addr,
  output logic [ACC_W-1:0]  acc
);

  logic [ACC_W-1:0]  acc_q, acc_d, acc_sum;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_sum;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              acc_ce, idx_ce, dat_ce;

  generate
    if (SHARED_ADDER) begin : g_one_adder
      logic [ACC_W-1:0] op_a, op_b, res;
      assign op_a    = inc_en ? ACC_W'(idx_q) : acc_q;
      assign op_b    = inc_en ? ACC_W'(1)     : ACC_W'(dat_q);
      assign res     = op_a + op_b;
      assign acc_sum = res;
      assign idx_sum = res[IDX_W-1:0];

      // R8
      one_op_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_en && inc_en));
    end else begin : g_two_adders
      assign acc_sum = acc_q + ACC_W'(dat_q);
      assign idx_sum = idx_q + IDX_W'(1);
    end
  endgenerate

  // 2-to-1 selects: clear value or computed value
  assign acc_d  = clr_en ? '0 : acc_sum;
  assign idx_d  = clr_en ? '0 : idx_sum;
  assign dat_d  = clr_en ? '0 : rdata;
  assign acc_ce = clr_en | add_en;
  assign idx_ce = clr_en | inc_en;
  assign dat_ce = clr_en | cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_ce) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_ce) dat_q <= dat_d;
  end

  assign idx_below = (idx_q < IDX_W'(WORDS));
  assign addr      = idx_q[ADDR_W-1:0];
  assign acc       = acc_q;

  // R2
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (acc_q == '0) && (idx_q == '0));

  // R5
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> acc_q == $past(acc_q) + ACC_W'($past(dat_q)));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> idx_q == $past(idx_q) + IDX_W'(1));

endmodule

// File: rtl/arrsum_engine.sv
module arrsum_engine #(
  parameter int DATA_W       = 8,
  parameter int WORDS        = 128,
  parameter bit SHARED_ADDER = 1'b0,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ACC_W  = DATA_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ACC_W-1:0]  sum,
  output logic              done
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       clr_en, cap_en, add_en, inc_en, idx_below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  arrsum_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .start     (start),
    .idx_below (idx_below),
    .clr_en    (clr_en),
    .rd_en     (mem_rd),
    .cap_en    (cap_en),
    .add_en    (add_en),
    .inc_en    (inc_en),
    .fin       (done)
  );

  arrsum_dpath #(
    .DATA_W       (DATA_W),
    .WORDS        (WORDS),
    .SHARED_ADDER (SHARED_ADDER)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clr_en    (clr_en),
    .cap_en    (cap_en),
    .add_en    (add_en),
    .inc_en    (inc_en),
    .rdata     (mem_rdata),
    .idx_below (idx_below),
    .addr      (mem_addr),
    .acc       (sum)
  );

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (done && !start) |=> done && $stable(sum));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    done |-> !mem_rd);

endmodule

// File: tb/arrsum_engine_test.sv
module arrsum_engine_test;

  localparam int DW  = 8;
  localparam int CNT = 128;
  localparam int AW  = 7;
  localparam int SW  = DW + AW;
  localparam int RUN_CYC = 5 * CNT + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic [AW-1:0] addr_a, addr_b;
  logic          rd_a, rd_b, done_a, done_b;
  logic [SW-1:0] sum_a, sum_b;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem [CNT];
  logic          pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int            rd_count = 0;
  int            addr_bad = 0;
  int            sh_mismatch = 0;
  logic [DW-1:0] junk = 8'h5a;

  always #2.5 clk = ~clk;

  arrsum_engine #(.DATA_W(DW), .WORDS(CNT), .SHARED_ADDER(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_a), .mem_rd(rd_a),
    .mem_rdata(rdata), .sum(sum_a), .done(done_a));

  arrsum_engine #(.DATA_W(DW), .WORDS(CNT), .SHARED_ADDER(1'b1)) uut_shared (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(addr_b), .mem_rd(rd_b),
    .mem_rdata(rdata), .sum(sum_b), .done(done_b));

  // memory model: data valid only in the cycle after a strobe, junk otherwise
  always @(negedge clk) begin
    junk = junk * 8'd29 + 8'd7;
    if (pend) rdata = mem[paddr];
    else      rdata = junk;
    pend  = rd_a;
    paddr = addr_a;
    if (rd_a) begin
      if (int'(addr_a) != rd_count) addr_bad++;
      rd_count++;
    end
    if (rd_a != rd_b || addr_a != addr_b || done_a != done_b) sh_mismatch++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int pat);
    for (int i = 0; i < CNT; i++) begin
      case (pat)
        0: mem[i] = '1;
        1: mem[i] = DW'(i);
        2: mem[i] = DW'((i * 37 + 11) ^ (i >> 2));
        default: mem[i] = '0;
      endcase
    end
  endtask

  task automatic run_pass(input int pat, input bit poke);
    int exp_sum;
    int n;
    fill(pat);
    exp_sum = 0;
    for (int i = 0; i < CNT; i++) exp_sum += int'(mem[i]);
    rd_count = 0; addr_bad = 0; sh_mismatch = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done_a && n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) begin
        // R2: cleared after the clearing state
        check("R2 sum cleared", 32'(sum_a), 32'd0);
      end
      if (poke && n == 100) start = 1'b1;
      if (poke && n == 101) start = 1'b0;
    end
    check("R9 cycles to done", 32'(n), 32'(RUN_CYC));
    check("R5 R4 final sum", 32'(sum_a), 32'(exp_sum));
    check("R8 shared sum", 32'(sum_b), 32'(exp_sum));
    check("R3 read count", 32'(rd_count), 32'(CNT));
    check("R3 address order", 32'(addr_bad), 32'd0);
    check("R8 shared strobe timing", 32'(sh_mismatch), 32'd0);
    if (poke) check("R7 busy start ignored", 32'(rd_count + n), 32'(CNT + RUN_CYC));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [SW-1:0] held;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 done in reset", 32'(done_a), 32'd0);
    check("R1 sum in reset", 32'(sum_a), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 done after reset", 32'(done_a), 32'd0);
    check("R1 rd after reset", 32'(rd_a), 32'd0);
    check("R1 sum after reset", 32'(sum_a), 32'd0);

    run_pass(0, 1'b0);  // full-scale words, R5 width
    run_pass(1, 1'b0);  // ascending words
    run_pass(2, 1'b1);  // scrambled words with busy start, R7
    run_pass(3, 1'b0);  // zeros after nonzero result, R2

    run_pass(1, 1'b0);
    held = sum_a;
    // R6: hold with junk on the data input
    repeat (25) @(negedge clk);
    check("R6 done held", 32'(done_a), 32'd1);
    check("R6 sum held", 32'(sum_a), 32'(held));
    check("R6 no reads while done", 32'(rd_count), 32'(CNT));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule